// File: doc/BRIEF.md
# Byte Mask and Shuffle Unit

This block performs byte-granular permutation of two 64-bit operands under control of a stored 32-bit selection mask. The mask lives in the upper half of a 64-bit status register. The lower half of that register is a general-purpose field written through its own port.

The unit accepts one operation per cycle, chosen by a single select bit.

- **Mask-set.** Adds two 64-bit operands. It returns the full sum as its result and loads the low 32 bits of the sum into the mask.
- **Shuffle.** Builds a 64-bit result from the two operands, one byte at a time. For each output byte, a 4-bit field of the mask selects one of the sixteen bytes held in the two operands.

Typical use is a mask-set that computes a permutation pattern, followed by one or more shuffles that apply it. The mask is committed in the cycle a mask-set issues. A shuffle in the very next cycle therefore already sees the new pattern, with no stall.

Top module: `byte_shuffle_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the whole status register (`status_q`) becomes zero and `res_valid` becomes 0.
- R2: A mask-set (`op_valid`=1, `op_kind`=0) drives `res_data` with the 64-bit sum `src_a + src_b`, modulo 2^64, one cycle after issue.
- R3: A mask-set loads `status_q[63:32]` with bits [31:0] of the sum. It leaves `status_q[31:0]` unchanged unless `low_we` is also high.
- R4: A shuffle (`op_valid`=1, `op_kind`=1) builds output byte i (bits 8i+7:8i, i = 0..7) from the selector `status_q[32+4i+3 : 32+4i]`. A selector value s in 0..7 picks byte s of `src_a`, where byte 0 is the least significant byte.
- R5: A selector value s in 8..15 picks byte (s-8) of `src_b`, with the same byte numbering as R4.
- R6: A shuffle issued in the cycle immediately after a mask-set uses the mask written by that mask-set.
- R7: When `low_we` is high, `status_q[31:0]` takes `low_wdata` at that edge and the mask half is unaffected. This holds even in the same cycle as a mask-set, in which case both halves update.
- R8: `res_valid` is high exactly one cycle after each issued operation and low otherwise. `res_data` holds its value when no operation issues.
- R9: A shuffle does not change the status register. Immediately after reset, a shuffle returns byte 0 of `src_a` in all eight output bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation issues this cycle |
| op_kind | input | 1 | 0 = mask-set, 1 = shuffle |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| low_we | input | 1 | Write enable for the status lower half |
| low_wdata | input | 32 | Data for the status lower half |
| res_valid | output | 1 | Result is valid this cycle |
| res_data | output | 64 | Registered result of the last operation |
| status_q | output | 64 | Status register: mask in [63:32], general field in [31:0] |

## Verification
Two functions can fall in the same cycle: a mask-set rewriting the upper half of the status register, and a port write to its lower half. The bench provokes this with directed cycles that issue both together, and with random traffic that raises `low_we` independently of the operation stream. Each such cycle is judged by comparing both halves of `status_q`, together with the returned sum, against a bench model that applies the two updates separately. Back-to-back mask-set then shuffle pairs are also issued, so that a stale mask would show up in the shuffled bytes.

// File: rtl/bsu_pkg.sv
// Package: shared types for the byte mask and shuffle unit.
// Assumes a single-bit operation select at the top level.
package bsu_pkg;
    typedef enum logic {
        OP_MASKSET = 1'b0,
        OP_SHUFFLE = 1'b1
    } bsu_op_e;
endpackage

// File: rtl/bsu_adder.sv
// Module: full-width adder for the mask-set operation.
// Assumes wrap-around arithmetic; no carry out is reported.
module bsu_adder #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] add_a,
    input  logic [DATA_W-1:0] add_b,
    output logic [DATA_W-1:0] add_sum
);
    // Combinational sum, modulo 2^DATA_W.
    always_comb begin
        add_sum = add_a + add_b;
    end
endmodule

// File: rtl/bsu_lane_sel.sv
// Module: picks one byte lane out of the two concatenated operands.
// Assumes sel indexes a pool of 2*DATA_W/LANE_W lanes, operand A in the low half.
module bsu_lane_sel #(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8,
    parameter int SEL_W  = 4
) (
    input  logic [2*DATA_W-1:0] pool,
    input  logic [SEL_W-1:0]    sel,
    output logic [LANE_W-1:0]   lane_o
);
    localparam int IDX_W = $clog2(2 * DATA_W);

    logic [IDX_W-1:0] base;

    // Bit offset of the selected lane inside the pool.
    always_comb begin
        base = IDX_W'(sel) * IDX_W'(LANE_W);
    end

    // Extract the selected lane.
    always_comb begin
        lane_o = pool[base +: LANE_W];
    end
endmodule

// File: rtl/bsu_status_reg.sv
// Module: 64-bit status register; upper half is the shuffle mask, lower half a general field.
// Assumes the two halves have independent enables so they can update in the same cycle.
module bsu_status_reg #(
    parameter int MASK_W = 32,
    parameter int LOW_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_we,
    input  logic [MASK_W-1:0] mask_wdata,
    input  logic              low_we,
    input  logic [LOW_W-1:0]  low_wdata,
    output logic [MASK_W-1:0] mask_q,
    output logic [LOW_W-1:0]  low_q
);
    // Mask half: cleared by reset, loaded by a mask-set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_we) begin
            mask_q <= mask_wdata;
        end
    end

    // Lower half: cleared by reset, loaded by the dedicated write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q <= '0;
        end else if (low_we) begin
            low_q <= low_wdata;
        end
    end
endmodule

// File: rtl/byte_shuffle_unit.sv
// Module: byte mask and shuffle unit (top).
// One operation per cycle: a mask-set adds the operands and loads the mask,
// a shuffle permutes bytes of {src_b, src_a} under the stored mask.
// Assumes the mask commits in the issue cycle, so the next shuffle needs no bypass.
module byte_shuffle_unit #(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8,
    parameter int LOW_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              op_kind,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic              low_we,
    input  logic [LOW_W-1:0]  low_wdata,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic [63:0]       status_q
);
    import bsu_pkg::*;

    localparam int NLANES = DATA_W / LANE_W;
    localparam int SEL_W  = $clog2(2 * NLANES);
    localparam int MASK_W = NLANES * SEL_W;

    bsu_op_e           op_e;
    logic [DATA_W-1:0] sum;
    logic [DATA_W-1:0] shuf;
    logic [MASK_W-1:0] mask_q;
    logic [LOW_W-1:0]  low_q;
    logic              mask_we;
    logic [2*DATA_W-1:0] pool;

    // Decode the operation select.
    always_comb begin
        op_e    = bsu_op_e'(op_kind);
        mask_we = op_valid && (op_e == OP_MASKSET);
        pool    = {src_b, src_a};
    end

    bsu_adder #(.DATA_W(DATA_W)) adder_i (
        .add_a   (src_a),
        .add_b   (src_b),
        .add_sum (sum)
    );

    bsu_status_reg #(.MASK_W(MASK_W), .LOW_W(LOW_W)) stat_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask_we    (mask_we),
        .mask_wdata (sum[MASK_W-1:0]),
        .low_we     (low_we),
        .low_wdata  (low_wdata),
        .mask_q     (mask_q),
        .low_q      (low_q)
    );

    // One selector per output lane.
    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        bsu_lane_sel #(.DATA_W(DATA_W), .LANE_W(LANE_W), .SEL_W(SEL_W)) sel_i (
            .pool   (pool),
            .sel    (mask_q[g*SEL_W +: SEL_W]),
            .lane_o (shuf[g*LANE_W +: LANE_W])
        );
    end

    // Result register: one-cycle latency, holds when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= op_valid;
            if (op_valid) begin
                res_data <= (op_e == OP_SHUFFLE) ? shuf : sum;
            end
        end
    end

    // Expose the status register as a 64-bit word.
    always_comb begin
        status_q = 64'({mask_q, low_q});
    end
endmodule

// File: rtl/bsu_checker.sv
// Module: property checker for byte_shuffle_unit, attached by bind.
// Assumes default parameters (64-bit data, 32-bit mask and lower half).
module bsu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic        op_kind,
    input logic [63:0] src_a,
    input logic [63:0] src_b,
    input logic        low_we,
    input logic [31:0] low_wdata,
    input logic        res_valid,
    input logic [63:0] res_data,
    input logic [63:0] status_q
);
    // R1: reset clears status and the valid flag.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (status_q == 64'd0 && !res_valid));

    // R2: mask-set returns the operand sum.
    a_r2_sum_result: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_kind) |=> (res_valid && res_data == $past(src_a + src_b)));

    // R3: mask-set loads the mask half from the low sum bits.
    a_r3_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_kind) |=> (status_q[63:32] == $past(src_a[31:0] + src_b[31:0])));

    // R7: the lower-half port writes the lower half.
    a_r7_low_write: assert property (@(posedge clk) disable iff (!rst_n)
        low_we |=> (status_q[31:0] == $past(low_wdata)));

    // R7: without a port write the lower half holds.
    a_r7_low_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !low_we |=> $stable(status_q[31:0]));

    // R8: valid follows issue by one cycle.
    a_r8_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);

    // R8: idle cycles give no valid and hold the result.
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!res_valid && $stable(res_data)));

    // R9: a shuffle leaves the mask unchanged.
    a_r9_shuffle_keeps_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid || op_kind) |=> $stable(status_q[63:32]));
endmodule

bind byte_shuffle_unit bsu_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_kind   (op_kind),
    .src_a     (src_a),
    .src_b     (src_b),
    .low_we    (low_we),
    .low_wdata (low_wdata),
    .res_valid (res_valid),
    .res_data  (res_data),
    .status_q  (status_q)
);

// File: tb/byte_shuffle_unit_tb_top.sv
`timescale 1ns/1ps
module byte_shuffle_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_kind = 1'b0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic        low_we = 1'b0;
    logic [31:0] low_wdata = '0;
    logic        res_valid;
    logic [63:0] res_data;
    logic [63:0] status_q;

    int n_checks = 0;
    int n_fails  = 0;

    logic [63:0] m_status = '0;
    logic [63:0] m_res    = '0;

    always #2.5 clk = ~clk;

    byte_shuffle_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .src_a(src_a), .src_b(src_b), .low_we(low_we), .low_wdata(low_wdata),
        .res_valid(res_valid), .res_data(res_data), .status_q(status_q)
    );

    function automatic logic [63:0] ref_shuffle(input logic [31:0] m,
                                                input logic [63:0] a,
                                                input logic [63:0] b);
        logic [63:0] r = '0;
        for (int i = 0; i < 8; i++) begin
            int s = int'((m >> (4 * i)) & 32'hF);
            if (s < 8) r[8*i +: 8] = a[8*s +: 8];
            else       r[8*i +: 8] = b[8*(s-8) +: 8];
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle at a negative edge, check the registered outcome at the next.
    task automatic step(input logic v, input logic k, input logic [63:0] a,
                        input logic [63:0] b, input logic lwe, input logic [31:0] ld,
                        input string tag);
        logic [63:0] sum;
        op_valid = v; op_kind = k; src_a = a; src_b = b; low_we = lwe; low_wdata = ld;
        sum = a + b;
        if (v) m_res = k ? ref_shuffle(m_status[63:32], a, b) : sum;
        if (v && !k) m_status[63:32] = sum[31:0];
        if (lwe) m_status[31:0] = ld;
        @(negedge clk);
        check({tag, " valid"}, 64'(res_valid), 64'(v));
        check({tag, " result"}, res_data, m_res);
        check({tag, " status"}, status_q, m_status);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 status", status_q, 64'd0);
        check("R1 valid", 64'(res_valid), 64'd0);
        rst_n = 1'b1;

        // R9: shuffle after reset replicates byte 0 of A
        step(1, 1, 64'h0807060504030201, 64'h1817161514131211, 0, 0, "R9");
        check("R9 replicate", res_data, 64'h0101010101010101);

        // R3/R6: identity mask then immediate shuffle
        step(1, 0, 64'h0000_0001_7654_3200, 64'h10, 0, 0, "R3");
        step(1, 1, 64'hA7A6A5A4A3A2A1A0, 64'hB7B6B5B4B3B2B1B0, 0, 0, "R6");
        check("R4 identity", res_data, 64'hA7A6A5A4A3A2A1A0);
        // R5: all selectors in the B range
        step(1, 0, 64'hFEDCBA98, 64'h0, 0, 0, "R3");
        step(1, 1, 64'hA7A6A5A4A3A2A1A0, 64'hB7B6B5B4B3B2B1B0, 0, 0, "R5");
        check("R5 from B", res_data, 64'hB7B6B5B4B3B2B1B0);
        // R4: byte reversal of A
        step(1, 0, 64'h01234567, 64'h0, 0, 0, "R3");
        step(1, 1, 64'hA7A6A5A4A3A2A1A0, 64'h0, 0, 0, "R4");
        check("R4 reverse", res_data, 64'hA0A1A2A3A4A5A6A7);
        // R2: wrap-around sum
        step(1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 0, 0, "R2");
        check("R2 wrap", res_data, 64'h0);
        // R3: carry out of low 32 bits does not reach the mask
        step(1, 0, 64'h0000_0000_FFFF_FFFF, 64'h1, 0, 0, "R3");
        check("R3 carry", status_q, 64'h0);
        // R7: lower write alone, then together with a mask-set
        step(0, 0, 64'h0, 64'h0, 1, 32'hCAFE_F00D, "R7");
        step(1, 0, 64'h5555_0000_1111_2222, 64'h0000_0000_0101_0101, 1, 32'h1357_9BDF, "R7");
        check("R7 both halves", status_q, 64'h1212_2323_1357_9BDF);
        // R8: idle holds result
        step(0, 1, 64'hDEAD, 64'hBEEF, 0, 0, "R8");
        step(0, 0, 64'h1, 64'h2, 0, 0, "R8");
        // R9: shuffle with lower write keeps mask
        step(1, 1, 64'h0, 64'h0, 1, 32'h2468_ACE0, "R9");

        // Random traffic
        void'($urandom(32'd7321));
        for (int n = 0; n < 600; n++) begin
            logic v = ($urandom % 8) != 0;
            logic k = $urandom % 2;
            logic w = ($urandom % 3) == 0;
            step(v, k, {$urandom, $urandom}, {$urandom, $urandom}, w, $urandom, "R2-R7 rand");
        end

        // R1: reset again mid-run
        rst_n = 1'b0;
        @(negedge clk);
        m_status = '0;
        check("R1 re-reset status", status_q, 64'd0);
        check("R1 re-reset valid", 64'(res_valid), 64'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule